// File: doc/BRIEF.md
# Descriptor Table Scatter-Gather Walker

This block walks a scatter-gather table for a bus-master storage DMA channel. A start pulse supplies the table base, the number of bytes the device side still wants moved, and the direction. The walker reads each 8-byte descriptor over a one-word read port. Each descriptor holds a region address and a size/flags word. The walker then cuts every region into transfer requests (address and byte length) for a separate data mover. It offers one request at a time on a valid/grant handshake.

A walk ends in three cases: the device budget reaches zero, a region marked as the last one has been used up, or the descriptor pointer has moved a full 4 KiB page past the table base. The walker raises an error instead when the sum of described region sizes for one command goes past a configurable maximum. On error it issues no further requests. The block moves no payload data and holds no registers visible to software.

Top module: `prd_walker`

## Requirements
- R1: A descriptor at pointer P is read as two 32-bit words: the region address at P, then the size/flags word at P+4, in that order. The pointer then advances by 8.
- R2: The region byte count is bits 15:0 of the size/flags word with bit 0 forced to zero. A masked count of zero means 65536 bytes. Bits 30:16 are ignored.
- R3: Bit 31 of the size/flags word flags the last region. Once that region is used up, the walk ends with `done_o` and no further descriptor is read.
- R4: Once a region is used up and the pointer is 4096 or more bytes past the table base, the walk ends with `done_o` even without a last flag. At most 512 descriptors are read.
- R5: Each request carries the smaller of the remaining budget and the bytes left in the current region. The region address advances by the granted length, so consecutive requests in one region are contiguous.
- R6: When the budget reaches zero, the walk ends with `done_o` and reads no further descriptor. A zero budget at start ends the walk with no read at all.
- R7: `start_i` while idle loads the pointer from `tbl_base_i` and captures `budget_i` and `dir_write_i`. Later changes to those inputs, and `start_i` pulses while busy, have no effect on the walk.
- R8: If the running sum of region sizes for one command exceeds `MAX_TOTAL`, the walker pulses `err_o` instead of `done_o` and issues no request for that region or any later one.
- R9: `req_write_o` equals the direction captured at start for every request.
- R10: After reset the block is idle: no read request, no transfer request, no done or error pulse.
- R11: A read request holds its address, and a transfer request holds its address and length, until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (taken only while idle) |
| dir_write_i | input | 1 | 1 = memory write transfer, 0 = memory read transfer |
| tbl_base_i | input | 32 | Descriptor table base address |
| budget_i | input | 32 | Bytes the device side needs for this command |
| rd_req_o | output | 1 | Descriptor word read request |
| rd_addr_o | output | 32 | Descriptor word address |
| rd_ack_i | input | 1 | Read accepted; `rd_data_i` valid in the same cycle |
| rd_data_i | input | 32 | Descriptor word, little-endian value |
| req_valid_o | output | 1 | Transfer request offered |
| req_addr_o | output | 32 | Transfer start address |
| req_len_o | output | 17 | Transfer byte count (1..65536) |
| req_write_o | output | 1 | Direction of the offered transfer |
| req_grant_i | input | 1 | Transfer request accepted |
| done_o | output | 1 | One-cycle pulse: walk finished normally |
| err_o | output | 1 | One-cycle pulse: size limit exceeded |
| busy_o | output | 1 | Walk in progress |

## Verification
The assertions assume that `rd_ack_i` and `req_grant_i` are raised only while the matching request is offered. They also assume `rd_data_i` is valid in the same cycle as `rd_ack_i`. The bench meets this by driving both acknowledges away from the clock edge, each one gated by its request output and a free-running pseudo-random bit, and by serving read data from a sparse memory at the presented address. Start pulses come from the bench task only. A deliberate start pulse during a walk covers the ignored-start case, so every other start lands while the block is idle.

// File: rtl/prd_walk_pkg.sv
package prd_walk_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned SZ_BITS    = 16;
  localparam int unsigned LEN_W      = SZ_BITS + 1;
  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned LAST_BIT   = 31;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CHECK    = 3'd1,
    ST_FETCH_LO = 3'd2,
    ST_FETCH_HI = 3'd3,
    ST_ISSUE    = 3'd4
  } walk_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              last;
  } prd_desc_t;

  // even byte count, zero encodes a full 64 KiB region
  function automatic logic [LEN_W-1:0] desc_len(input logic [SZ_BITS-1:0] sz);
    logic [SZ_BITS-1:0] m;
    m = {sz[SZ_BITS-1:1], 1'b0};
    if (m == '0) desc_len = {1'b1, {SZ_BITS{1'b0}}};
    else         desc_len = {1'b0, m};
  endfunction
endpackage

// File: rtl/prd_fetch.sv
module prd_fetch
  import prd_walk_pkg::*;
#(
  parameter int unsigned TBL_LIMIT = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              want_lo_i,
  input  logic              want_hi_i,
  input  logic              rd_ack_i,
  input  logic [31:0]       rd_data_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              desc_valid_o,
  output prd_desc_t         desc_o,
  output logic              limit_o
);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(DESC_BYTES);
  localparam logic [ADDR_W-1:0] HI_OF = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(TBL_LIMIT);

  logic [ADDR_W-1:0] base_q, ptr_q, lo_q;
  logic              unused_rsvd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ptr_q  <= '0;
      lo_q   <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      ptr_q  <= base_i;
    end else if (want_lo_i && rd_ack_i) begin
      lo_q <= rd_data_i;
    end else if (want_hi_i && rd_ack_i) begin
      ptr_q <= ptr_q + STEP;
    end
  end

  assign rd_req_o     = want_lo_i | want_hi_i;
  assign rd_addr_o    = want_hi_i ? ptr_q + HI_OF : ptr_q;
  assign desc_valid_o = want_hi_i & rd_ack_i;
  assign desc_o       = '{addr: lo_q,
                          len:  desc_len(rd_data_i[SZ_BITS-1:0]),
                          last: rd_data_i[LAST_BIT]};
  assign limit_o      = (ptr_q - base_q) >= LIMIT;
  assign unused_rsvd  = ^rd_data_i[LAST_BIT-1:SZ_BITS];
endmodule

// File: rtl/prd_region.sv
module prd_region
  import prd_walk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              desc_valid_i,
  input  prd_desc_t         desc_i,
  input  logic              take_i,
  input  logic [LEN_W-1:0]  take_len_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [LEN_W-1:0]  rem_o,
  output logic              last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_addr_o <= '0;
      rem_o      <= '0;
      last_o     <= 1'b0;
    end else if (clear_i) begin
      cur_addr_o <= '0;
      rem_o      <= '0;
      last_o     <= 1'b0;
    end else if (desc_valid_i) begin
      cur_addr_o <= desc_i.addr;
      rem_o      <= desc_i.len;
      last_o     <= desc_i.last;
    end else if (take_i) begin
      cur_addr_o <= cur_addr_o + ADDR_W'(take_len_i);
      rem_o      <= rem_o - take_len_i;
    end
  end
endmodule

// File: rtl/prd_ctrl.sv
module prd_ctrl
  import prd_walk_pkg::*;
#(
  parameter logic [31:0] MAX_TOTAL = 32'h7FFF_FFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      budget_i,
  input  logic             dir_i,
  input  logic             limit_i,
  input  logic [LEN_W-1:0] rem_i,
  input  logic             last_i,
  input  logic             rd_ack_i,
  input  logic             desc_valid_i,
  input  logic [LEN_W-1:0] desc_len_i,
  input  logic             req_grant_i,
  output logic             load_o,
  output logic             want_lo_o,
  output logic             want_hi_o,
  output logic             req_valid_o,
  output logic [LEN_W-1:0] chunk_o,
  output logic             req_write_o,
  output logic             take_o,
  output logic             done_o,
  output logic             err_o,
  output logic             busy_o
);
  localparam int unsigned TOT_W = 34;

  walk_st_e         st_q, st_d;
  logic [31:0]      need_q;
  logic [TOT_W-1:0] total_q, sum;
  logic             dir_q, fin, fail, over;

  assign load_o      = (st_q == ST_IDLE) && start_i;
  assign want_lo_o   = (st_q == ST_FETCH_LO);
  assign want_hi_o   = (st_q == ST_FETCH_HI);
  assign req_valid_o = (st_q == ST_ISSUE);
  assign take_o      = req_valid_o && req_grant_i;
  assign req_write_o = dir_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign chunk_o     = (need_q < 32'(rem_i)) ? need_q[LEN_W-1:0] : rem_i;
  assign sum         = total_q + TOT_W'(desc_len_i);
  assign over        = sum > TOT_W'(MAX_TOTAL);

  always_comb begin
    st_d = st_q;
    fin  = 1'b0;
    fail = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_CHECK;
      ST_CHECK: begin
        if (need_q == '0) begin
          fin  = 1'b1;
          st_d = ST_IDLE;
        end else if (rem_i == '0) begin
          if (last_i || limit_i) begin
            fin  = 1'b1;
            st_d = ST_IDLE;
          end else begin
            st_d = ST_FETCH_LO;
          end
        end else begin
          st_d = ST_ISSUE;
        end
      end
      ST_FETCH_LO: if (rd_ack_i) st_d = ST_FETCH_HI;
      ST_FETCH_HI: begin
        if (desc_valid_i) begin
          if (over) begin
            fail = 1'b1;
            st_d = ST_IDLE;
          end else begin
            st_d = ST_CHECK;
          end
        end
      end
      ST_ISSUE: if (req_grant_i) st_d = ST_CHECK;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      need_q  <= '0;
      total_q <= '0;
      dir_q   <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= fin;
      err_o  <= fail;
      if (load_o) begin
        need_q  <= budget_i;
        total_q <= '0;
        dir_q   <= dir_i;
      end else begin
        if (take_o)       need_q  <= need_q - 32'(chunk_o);
        if (desc_valid_i) total_q <= sum;
      end
    end
  end
endmodule

// File: rtl/prd_walker.sv
module prd_walker
  import prd_walk_pkg::*;
#(
  parameter int unsigned TBL_LIMIT = 4096,
  parameter logic [31:0] MAX_TOTAL = 32'h7FFF_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_write_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [31:0]       budget_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [31:0]       rd_data_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              req_write_o,
  input  logic              req_grant_i,
  output logic              done_o,
  output logic              err_o,
  output logic              busy_o
);
  logic             load, want_lo, want_hi, desc_valid, limit, take, last;
  logic [LEN_W-1:0] rem, chunk;
  prd_desc_t        desc;

  prd_fetch #(.TBL_LIMIT(TBL_LIMIT)) u_fetch (
    .clk_i, .rst_ni,
    .load_i(load), .base_i(tbl_base_i),
    .want_lo_i(want_lo), .want_hi_i(want_hi),
    .rd_ack_i, .rd_data_i, .rd_req_o, .rd_addr_o,
    .desc_valid_o(desc_valid), .desc_o(desc), .limit_o(limit)
  );

  prd_region u_region (
    .clk_i, .rst_ni,
    .clear_i(load), .desc_valid_i(desc_valid), .desc_i(desc),
    .take_i(take), .take_len_i(chunk),
    .cur_addr_o(req_addr_o), .rem_o(rem), .last_o(last)
  );

  prd_ctrl #(.MAX_TOTAL(MAX_TOTAL)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i, .budget_i, .dir_i(dir_write_i),
    .limit_i(limit), .rem_i(rem), .last_i(last),
    .rd_ack_i, .desc_valid_i(desc_valid), .desc_len_i(desc.len),
    .req_grant_i,
    .load_o(load), .want_lo_o(want_lo), .want_hi_o(want_hi),
    .req_valid_o, .chunk_o(chunk), .req_write_o,
    .take_o(take), .done_o, .err_o, .busy_o
  );

  assign req_len_o = chunk;
endmodule

// File: rtl/prd_walker_chk.sv
module prd_walker_chk
  import prd_walk_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ack_i,
  input logic              req_valid_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [LEN_W-1:0]  req_len_o,
  input logic              req_grant_i,
  input logic              done_o,
  input logic              err_o,
  input logic              busy_o
);
  assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_grant_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_len_o));

  assert_len_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_len_o != '0) && (req_len_o <= {1'b1, {SZ_BITS{1'b0}}}));

  assert_one_port_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && req_valid_o));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_req_o && !req_valid_o);

  assert_end_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  assert_err_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind prd_walker prd_walker_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
  .req_valid_o(req_valid_o), .req_addr_o(req_addr_o), .req_len_o(req_len_o),
  .req_grant_i(req_grant_i), .done_o(done_o), .err_o(err_o), .busy_o(busy_o)
);

// File: tb/prd_walker_tb_top.sv
module prd_walker_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] MAX_T      = 32'd150000;
  localparam int          WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        dir_write_i = 1'b0;
  logic [31:0] tbl_base_i = '0;
  logic [31:0] budget_i = '0;
  logic        rd_req_o;
  logic [31:0] rd_addr_o;
  logic        rd_ack_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        req_valid_o;
  logic [31:0] req_addr_o;
  logic [16:0] req_len_o;
  logic        req_write_o;
  logic        req_grant_i = 1'b0;
  logic        done_o, err_o, busy_o;

  prd_walker #(.TBL_LIMIT(4096), .MAX_TOTAL(MAX_T)) dut_i (
    .clk_i(clk), .rst_ni, .start_i, .dir_write_i, .tbl_base_i, .budget_i,
    .rd_req_o, .rd_addr_o, .rd_ack_i, .rd_data_i,
    .req_valid_o, .req_addr_o, .req_len_o, .req_write_o, .req_grant_i,
    .done_o, .err_o, .busy_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [int unsigned];
  int unsigned fetch_q [$];
  logic [31:0] caddr_q [$];
  int unsigned clen_q  [$];
  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   seen_done = 0, seen_err = 0, exp_dir = 0;
  logic [7:0] lf = 8'h5A;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] a, input logic [31:0] sz);
    mem[at]     = a;
    mem[at + 4] = sz;
  endtask

  // behavioural reference: returns 1 when the walk is expected to end in error
  function automatic bit model(input logic [31:0] base, input logic [31:0] budget);
    longint      need, rem, total, ch;
    logic [31:0] ptr, cur, hi;
    bit          last;
    fetch_q.delete(); caddr_q.delete(); clen_q.delete();
    ptr = base; need = budget; rem = 0; total = 0; cur = 0; last = 0;
    for (int it = 0; it < 5000; it++) begin
      if (need == 0) return 0;
      if (rem == 0) begin
        if (last || (ptr - base) >= 32'd4096) return 0;
        fetch_q.push_back(ptr);
        fetch_q.push_back(ptr + 4);
        hi   = mem_rd(ptr + 4);
        rem  = hi[15:0] & 16'hFFFE;
        if (rem == 0) rem = 65536;
        total += rem;
        if (total > longint'(MAX_T)) return 1;
        cur  = mem_rd(ptr);
        last = hi[31];
        ptr  = ptr + 8;
      end else begin
        ch = (need < rem) ? need : rem;
        caddr_q.push_back(cur);
        clen_q.push_back(int'(ch));
        cur  = cur + 32'(ch);
        rem  -= ch;
        need -= ch;
      end
    end
    return 0;
  endfunction

  // acknowledge, data and comparison, all away from the active edge
  always @(negedge clk) begin
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    rd_ack_i  = rd_req_o && (lf[0] || lf[3]);
    rd_data_i = mem_rd(rd_addr_o);
    if (rd_ack_i) begin
      if (fetch_q.size() == 0)
        chk(0, "R1", "unexpected descriptor read", rd_addr_o, 0);
      else
        chk(rd_addr_o == fetch_q.pop_front(), "R1", "descriptor read address", rd_addr_o, 0);
    end
    req_grant_i = req_valid_o && (lf[1] || lf[6]);
    if (req_valid_o)
      chk(req_write_o == exp_dir, "R9", "request direction", req_write_o, exp_dir);
    if (req_grant_i) begin
      if (caddr_q.size() == 0) begin
        chk(0, "R5", "unexpected transfer request", req_addr_o, 0);
      end else begin
        chk(req_addr_o == caddr_q[0], "R5", "request address", req_addr_o, caddr_q[0]);
        chk(int'(req_len_o) == clen_q[0], "R2", "request length", req_len_o, clen_q[0]);
        void'(caddr_q.pop_front());
        void'(clen_q.pop_front());
      end
    end
    if (done_o) seen_done = 1;
    if (err_o)  seen_err  = 1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run_case(input string req, input logic [31:0] base, input logic [31:0] budget,
                          input bit dir, input bit poke);
    bit e;
    e = model(base, budget);
    exp_dir = dir; seen_done = 0; seen_err = 0;
    @(negedge clk);
    tbl_base_i = base; budget_i = budget; dir_write_i = dir; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; tbl_base_i = 32'hDEAD_0000; budget_i = 32'd5; dir_write_i = ~dir;
    chk(busy_o == 1'b1, "R7", "busy after start", busy_o, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1; budget_i = 32'd2;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int k = 0; k < 20000 && !(seen_done || seen_err); k++) @(negedge clk);
    @(negedge clk);
    chk(seen_err == e,  e ? "R8" : "R6", "error pulse", seen_err, e);
    chk(seen_done == !e, e ? "R8" : "R3", "done pulse", seen_done, !e);
    chk(fetch_q.size() == 0, req, "descriptor reads missing", fetch_q.size(), 0);
    chk(caddr_q.size() == 0, req, "transfer requests missing", caddr_q.size(), 0);
    chk(busy_o == 1'b0, req, "idle after end", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_req_o && !req_valid_o && !busy_o && !done_o && !err_o, "R10",
        "outputs in reset", {rd_req_o, req_valid_o, busy_o, done_o, err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !rd_req_o, "R10", "idle after reset", busy_o, 0);

    // R2 odd size word rounded down, single last region
    put_desc(32'h1000, 32'h0010_0000, 32'h8000_0101);
    run_case("R2", 32'h1000, 32'h100, 1'b0, 1'b0);

    // R5 budget ends inside second region; R7 start while busy ignored
    put_desc(32'h2000, 32'h0002_0000, 32'h0000_0040);
    put_desc(32'h2008, 32'h0003_0002, 32'h0000_0031);
    put_desc(32'h2010, 32'h0004_0000, 32'h8000_0100);
    run_case("R7", 32'h2000, 32'd100, 1'b1, 1'b1);

    // R3 table ends on last flag with budget left; entry after it never read
    put_desc(32'h3000, 32'h0006_0000, 32'h0000_0010);
    put_desc(32'h3008, 32'h0007_0000, 32'h8000_0020);
    put_desc(32'h3010, 32'h0008_0000, 32'h0000_0040);
    run_case("R3", 32'h3000, 32'd1000, 1'b0, 1'b0);

    // R2 masked zero count means 65536, upper flag bits ignored
    put_desc(32'h4000, 32'h0050_0000, 32'h8001_0000);
    run_case("R2", 32'h4000, 32'h0002_0000, 1'b1, 1'b0);

    // R4 no end marker: page limit stops after 512 descriptors
    for (int i = 0; i < 520; i++)
      put_desc(32'h0001_0000 + 32'(i * 8), 32'h0100_0000 + 32'(i * 16), 32'h0000_0003);
    run_case("R4", 32'h0001_0000, 32'hFFFF_FFFF, 1'b0, 1'b0);

    // R8 running total passes the limit on the third region
    put_desc(32'h5000, 32'h0200_0000, 32'h0000_0000);
    put_desc(32'h5008, 32'h0300_0000, 32'h0000_0000);
    put_desc(32'h5010, 32'h0400_0000, 32'h0000_0000);
    run_case("R8", 32'h5000, 32'hFFFF_FFFF, 1'b1, 1'b0);

    // R6 zero budget: no descriptor read at all
    run_case("R6", 32'h1000, 32'd0, 1'b0, 1'b0);

    // R7 table base reloaded on a fresh start, R9 other direction
    run_case("R7", 32'h1000, 32'h80, 1'b1, 1'b0);
    run_case("R1", 32'h3000, 32'd20, 1'b1, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule